// File: doc/BRIEF.md
# CAN Receive Acceptance Filter

This block decides which of sixteen message slots takes a frame that a CAN controller has just received. Each slot holds an identifier, a format flag (standard or extended) and an enable flag. When the receiver strobes in an identifier, every enabled slot compares it against its own stored identifier. Only the bits that the slot's mask marks as significant take part in the comparison. The lowest-numbered slot that matches is reported, together with a hit flag, one clock after the strobe.

Slots 0 to 13 all use a single shared mask. Slot 14 has a private mask of its own, and slot 15 has another. A mask may only be changed while the slots it governs have no receive request pending. A write that arrives while a request is pending is dropped, so a frame is never filtered against a half-updated mask.

Slot and mask contents are loaded through a plain write port. Bit-level reception, storage of the frame payload and bus timing are handled elsewhere.

Top module: `can_accept_filter`

## Requirements
- R1: A write with `regAddr` 0 to 15 loads that slot. `regWrData[28:0]` is the slot identifier, bit 29 is the format flag (1 = extended), and bit 30 is the receive enable.
- R2: A write to `regAddr` 16 loads the shared mask, 17 loads the slot-14 mask and 18 loads the slot-15 mask, each from `regWrData[28:0]`. All three masks reset to zero.
- R3: A mask bit of 0 makes that identifier bit a don't-care.
- R4: A mask bit of 1 requires the received bit to equal the stored slot bit.
- R5: The shared mask applies only to slots 0 to 13. The slot-14 mask applies only to slot 14, and the slot-15 mask only to slot 15.
- R6: A slot takes part in matching only when its enable flag is set and its format flag equals `rxExt`.
- R7: Identifier bits [10:0] are the standard identifier and bits [28:11] are the 18-bit extension. For a standard frame (`rxExt`=0), only bits [10:0] are compared.
- R8: When several slots match, the lowest slot index is reported.
- R9: `hitValid` and `hitSlot` are registered and appear on the clock edge after the one that samples `rxValid`. On a miss, or when there was no strobe, `hitValid` is 0 and `hitSlot` is 0.
- R10: A write to the shared mask is ignored while any of `slotRxReq[13:0]` is 1. Requests on slots 14 and 15 do not block it.
- R11: A write to the slot-14 mask is ignored while `slotRxReq[14]` is 1. A write to the slot-15 mask is ignored while `slotRxReq[15]` is 1.
- R12: After reset every slot is disabled, so no strobe produces a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 5 | Register address (0-15 slots, 16-18 masks) |
| regWrData | input | 31 | Write data |
| slotRxReq | input | 16 | Per-slot receive request pending |
| rxValid | input | 1 | Received identifier strobe |
| rxId | input | 29 | Received identifier |
| rxExt | input | 1 | Received frame format (1 = extended) |
| hitValid | output | 1 | A slot matched the strobed identifier |
| hitSlot | output | 4 | Index of the winning slot |

## Verification
The filter result is due exactly one clock after `rxValid` is sampled. The bench raises the strobe on a falling edge and reads `hitValid` and `hitSlot` on the next falling edge, one half period after the capturing rising edge. A register write takes effect at the rising edge that samples it. The bench therefore drops the write at the following falling edge, and the next strobe it issues already sees the new content. Ignored mask writes are checked through a later strobe whose outcome would differ if the write had landed.

// File: rtl/canf_pkg.sv
package canf_pkg;
  localparam int NUM_SLOTS  = 16;
  localparam int ID_W       = 29;
  localparam int STD_W      = 11;
  localparam int IDX_W      = $clog2(NUM_SLOTS);
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = ID_W + 2;
  localparam int EXT_BIT    = ID_W;
  localparam int EN_BIT     = ID_W + 1;
  localparam int SHARED_CNT = NUM_SLOTS - 2;

  localparam logic [ADDR_W-1:0] GMASK_ADDR = ADDR_W'(NUM_SLOTS);
  localparam logic [ADDR_W-1:0] AMASK_ADDR = ADDR_W'(NUM_SLOTS + 1);
  localparam logic [ADDR_W-1:0] BMASK_ADDR = ADDR_W'(NUM_SLOTS + 2);

  typedef struct packed {
    logic            en;
    logic            ext;
    logic [ID_W-1:0] id;
  } slotCfg_t;

  typedef struct packed {
    logic [NUM_SLOTS-1:0] slotWe;
    logic                 gWe;
    logic                 aWe;
    logic                 bWe;
  } wrStrobes_t;
endpackage

// File: rtl/canf_ctrl.sv
module canf_ctrl
  import canf_pkg::*;
(
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [NUM_SLOTS-1:0] slotRxReq,
  output wrStrobes_t           strobes
);
  logic sharedBusy;

  assign sharedBusy = |slotRxReq[SHARED_CNT-1:0];

  always_comb begin
    strobes = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      strobes.slotWe[i] = regWrEn && (regAddr == ADDR_W'(i));
    end
    strobes.gWe = regWrEn && (regAddr == GMASK_ADDR) && !sharedBusy;
    strobes.aWe = regWrEn && (regAddr == AMASK_ADDR) && !slotRxReq[NUM_SLOTS-2];
    strobes.bWe = regWrEn && (regAddr == BMASK_ADDR) && !slotRxReq[NUM_SLOTS-1];
  end
endmodule

// File: rtl/canf_datapath.sv
module canf_datapath
  import canf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobes_t        strobes,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              rxValid,
  input  logic [ID_W-1:0]   rxId,
  input  logic              rxExt,
  output logic              hitValid,
  output logic [IDX_W-1:0]  hitSlot,
  output logic [ID_W-1:0]   gMask,
  output logic [ID_W-1:0]   aMask,
  output logic [ID_W-1:0]   bMask
);
  localparam logic [ID_W-1:0] STD_ONLY = {{(ID_W-STD_W){1'b0}}, {STD_W{1'b1}}};

  slotCfg_t             slotQ [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] hitVec;
  logic [ID_W-1:0]      cmpBits;
  logic                 anyHit;
  logic [IDX_W-1:0]     winIdx;

  assign cmpBits = rxExt ? '1 : STD_ONLY;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gMask <= '0;
      aMask <= '0;
      bMask <= '0;
    end else begin
      if (strobes.gWe) gMask <= regWrData[ID_W-1:0];
      if (strobes.aWe) aMask <= regWrData[ID_W-1:0];
      if (strobes.bWe) bMask <= regWrData[ID_W-1:0];
    end
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : gSlot
    logic [ID_W-1:0] useMask;

    if (s < SHARED_CNT) begin : gShared
      assign useMask = gMask;
    end else if (s == NUM_SLOTS - 2) begin : gLocalA
      assign useMask = aMask;
    end else begin : gLocalB
      assign useMask = bMask;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotQ[s] <= '0;
      end else if (strobes.slotWe[s]) begin
        slotQ[s].id  <= regWrData[ID_W-1:0];
        slotQ[s].ext <= regWrData[EXT_BIT];
        slotQ[s].en  <= regWrData[EN_BIT];
      end
    end

    assign hitVec[s] = slotQ[s].en && (slotQ[s].ext == rxExt) &&
                       (((rxId ^ slotQ[s].id) & useMask & cmpBits) == '0);
  end

  always_comb begin
    anyHit = |hitVec;
    winIdx = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (hitVec[i]) winIdx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hitValid <= 1'b0;
      hitSlot  <= '0;
    end else if (rxValid && anyHit) begin
      hitValid <= 1'b1;
      hitSlot  <= winIdx;
    end else begin
      hitValid <= 1'b0;
      hitSlot  <= '0;
    end
  end
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
  import canf_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [DATA_W-1:0]    regWrData,
  input  logic [NUM_SLOTS-1:0] slotRxReq,
  input  logic                 rxValid,
  input  logic [ID_W-1:0]      rxId,
  input  logic                 rxExt,
  output logic                 hitValid,
  output logic [IDX_W-1:0]     hitSlot
);
  wrStrobes_t      strobes;
  logic [ID_W-1:0] gMask;
  logic [ID_W-1:0] aMask;
  logic [ID_W-1:0] bMask;

  canf_ctrl ctrl_i (
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .slotRxReq(slotRxReq),
    .strobes  (strobes)
  );

  canf_datapath dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .regWrData(regWrData),
    .rxValid  (rxValid),
    .rxId     (rxId),
    .rxExt    (rxExt),
    .hitValid (hitValid),
    .hitSlot  (hitSlot),
    .gMask    (gMask),
    .aMask    (aMask),
    .bMask    (bMask)
  );
endmodule

// File: rtl/canf_checker.sv
module canf_checker
  import canf_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 regWrEn,
  input logic [ADDR_W-1:0]    regAddr,
  input logic [DATA_W-1:0]    regWrData,
  input logic [NUM_SLOTS-1:0] slotRxReq,
  input logic                 rxValid,
  input logic                 hitValid,
  input logic [IDX_W-1:0]     hitSlot,
  input logic [ID_W-1:0]      gMask,
  input logic [ID_W-1:0]      aMask,
  input logic [ID_W-1:0]      bMask
);
  AST_MASK_RESET: assert property (@(posedge clk) !rstN |=> (gMask == '0 && aMask == '0 && bMask == '0)); // R2
  AST_GMASK_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == GMASK_ADDR && |slotRxReq[SHARED_CNT-1:0]) |=> $stable(gMask)); // R10
  AST_GMASK_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == GMASK_ADDR && !(|slotRxReq[SHARED_CNT-1:0])) |=> gMask == $past(regWrData[ID_W-1:0])); // R10
  AST_AMASK_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == AMASK_ADDR && slotRxReq[NUM_SLOTS-2]) |=> $stable(aMask)); // R11
  AST_BMASK_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == BMASK_ADDR && slotRxReq[NUM_SLOTS-1]) |=> $stable(bMask)); // R11
  AST_NO_STROBE_NO_HIT: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |=> !hitValid); // R9
  AST_MISS_SLOT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !hitValid |-> hitSlot == '0); // R9
endmodule

bind can_accept_filter canf_checker chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .regWrEn  (regWrEn),
  .regAddr  (regAddr),
  .regWrData(regWrData),
  .slotRxReq(slotRxReq),
  .rxValid  (rxValid),
  .hitValid (hitValid),
  .hitSlot  (hitSlot),
  .gMask    (gMask),
  .aMask    (aMask),
  .bMask    (bMask)
);

// File: tb/can_accept_filter_tb_top.sv
module can_accept_filter_tb_top;
  import canf_pkg::*;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 regWrEn = 1'b0;
  logic [ADDR_W-1:0]    regAddr = '0;
  logic [DATA_W-1:0]    regWrData = '0;
  logic [NUM_SLOTS-1:0] slotRxReq = '0;
  logic                 rxValid = 1'b0;
  logic [ID_W-1:0]      rxId = '0;
  logic                 rxExt = 1'b0;
  logic                 hitValid;
  logic [IDX_W-1:0]     hitSlot;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  can_accept_filter dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .slotRxReq(slotRxReq), .rxValid(rxValid),
    .rxId(rxId), .rxExt(rxExt), .hitValid(hitValid), .hitSlot(hitSlot)
  );

  // {id, ext, expected hit, expected slot}
  localparam int NVEC = 11;
  localparam logic [ID_W+5:0] VEC [NVEC] = '{
    {29'h00000123, 1'b0, 1'b1, 4'd0},   // R4 exact standard match
    {29'h1FFFF123, 1'b0, 1'b1, 4'd0},   // R7 extension bits ignored on standard frame
    {29'h00000124, 1'b0, 1'b0, 4'd0},   // R4 one differing bit misses
    {29'h000007A5, 1'b0, 1'b1, 4'd14},  // R3 R5 local mask A don't-care bits
    {29'h000007AF, 1'b0, 1'b1, 4'd14},  // R3
    {29'h000007B0, 1'b0, 1'b0, 4'd0},   // R4 R5 masked bit differs
    {29'h00000456, 1'b0, 1'b0, 4'd0},   // R6 disabled slot
    {29'h0ABCD123, 1'b1, 1'b1, 4'd1},   // R6 extended match
    {29'h00000123, 1'b1, 1'b1, 4'd15},  // R6 format mismatch skips slot 0, mask B zero
    {29'h0ABCD122, 1'b1, 1'b1, 4'd15},  // R5
    {29'h000003FF, 1'b0, 1'b1, 4'd5}    // R1
  };

  task automatic check(input string tag, input logic expHit, input logic [IDX_W-1:0] expSlot);
    total++;
    if (hitValid !== expHit || hitSlot !== expSlot) begin
      bad++;
      $display("FAIL %s: hitValid=%0b hitSlot=%0d expected hitValid=%0b hitSlot=%0d",
               tag, hitValid, hitSlot, expHit, expSlot);
    end
  endtask

  task automatic wrReg(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic wrSlot(input int s, input logic en, input logic ext, input logic [ID_W-1:0] id);
    wrReg(ADDR_W'(s), {en, ext, id});
  endtask

  task automatic probe(input string tag, input logic [ID_W-1:0] id, input logic ext,
                       input logic expHit, input logic [IDX_W-1:0] expSlot);
    @(negedge clk);
    rxValid = 1'b1; rxId = id; rxExt = ext;
    @(negedge clk);
    rxValid = 1'b0;
    check(tag, expHit, expSlot);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++;
      $display("FAIL watchdog: cycles=%0d expected finish", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R12 reset outputs", 1'b0, 4'd0);
    rstN = 1'b1;
    probe("R12 no slot enabled after reset", 29'h0, 1'b0, 1'b0, 4'd0);

    // masks are zero after reset: any standard id hits slot 5
    wrSlot(5, 1'b1, 1'b0, 29'h3FF);
    probe("R2 R3 zero mask matches anything", 29'h000, 1'b0, 1'b1, 4'd5);

    wrReg(GMASK_ADDR, {2'b00, 29'h1FFFFFFF});
    wrReg(AMASK_ADDR, {2'b00, 29'h000007F0});
    wrReg(BMASK_ADDR, '0);
    wrSlot(0, 1'b1, 1'b0, 29'h123);
    wrSlot(1, 1'b1, 1'b1, 29'h0ABCD123);
    wrSlot(2, 1'b1, 1'b0, 29'h123);
    wrSlot(3, 1'b0, 1'b0, 29'h456);
    wrSlot(14, 1'b1, 1'b0, 29'h7A0);
    wrSlot(15, 1'b1, 1'b1, 29'h55);

    for (int v = 0; v < NVEC; v++) begin
      probe($sformatf("R4 R8 vector %0d", v), VEC[v][ID_W+5:6], VEC[v][5], VEC[v][4], VEC[v][3:0]);
    end

    @(negedge clk);
    check("R9 idle cycle no hit", 1'b0, 4'd0);

    // R10: locked shared mask write
    slotRxReq = 16'h0008;
    wrReg(GMASK_ADDR, '0);
    slotRxReq = '0;
    probe("R10 shared mask write ignored", 29'h124, 1'b0, 1'b0, 4'd0);

    // R11: locked mask A write
    slotRxReq = 16'h4000;
    wrReg(AMASK_ADDR, '0);
    slotRxReq = '0;
    probe("R11 mask A write ignored", 29'h7B0, 1'b0, 1'b0, 4'd0);

    // R11: locked mask B write
    slotRxReq = 16'h8000;
    wrReg(BMASK_ADDR, {2'b00, 29'h1FFFFFFF});
    slotRxReq = '0;
    probe("R11 mask B write ignored", 29'h123, 1'b1, 1'b1, 4'd15);

    wrReg(BMASK_ADDR, {2'b00, 29'h1FFFFFFF});
    probe("R11 mask B write accepted", 29'h123, 1'b1, 1'b0, 4'd0);

    // R10: requests on slots 14 and 15 do not block the shared mask
    slotRxReq = 16'hC000;
    wrReg(GMASK_ADDR, '0);
    slotRxReq = '0;
    probe("R10 shared mask write accepted", 29'h124, 1'b0, 1'b1, 4'd0);

    // R8: with shared mask zero slot 0 beats slot 2 and 5
    probe("R8 lowest index wins", 29'h3FF, 1'b0, 1'b1, 4'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule